// File: doc/BRIEF.md
# Reset-Dominant Timer Latch Core

This block is a clocked digital model of the latch at the heart of a classic timer circuit. It takes two sampled 8-bit level codes. The threshold code is compared against a control level. The trigger code is compared against half of that control level. A third input is an active-low clear. The comparisons, together with the clear, drive a set/reset state in which reset always wins. The state is presented twice: as a plain logic output, and as an open-drain discharge output. The discharge output is modelled as a pull-low enable plus a pad value that floats when the state is 1.

The control level is 170 (two thirds of full scale 255) unless an override input selects an externally supplied code. A mode input turns the block into a transparent D latch. In that mode an enable/data pair replaces the comparator and clear inputs. Tying the threshold and trigger codes to one signal gives an AND-NOT gate with hysteresis.

The pipeline has two stages. Input decisions are registered on one rising edge, and the state updates on the next edge. An output therefore reflects inputs applied two edges earlier.

Top module: `timer_latch_core`

## Requirements
- R1: The threshold request is active when `thr_code` is strictly greater than the effective control code. A code equal to the control code does not clear the state.
- R2: The trigger request is active when `trg_code` is strictly less than the effective control code shifted right by one. A code equal to that half does not set the state.
- R3: With `ctl_ovr` = 0 the effective control code is 170, which places the trigger half at 85. With `ctl_ovr` = 1 the effective control code is `ctl_code`.
- R4: When the trigger is active, `clr_n` is 1 and the threshold is inactive, `q` becomes 1 on the second rising edge after the inputs are applied.
- R5: When the threshold is active or `clr_n` is 0, `q` becomes 0 on the second rising edge. This holds even when the trigger is active at the same time.
- R6: When there is neither a set request nor a clear request, `q` keeps its value.
- R7: `dis_pull` is always the inverse of `q`. `dis_pad` is 0 while `dis_pull` is 1, and high-impedance (z) while `dis_pull` is 0.
- R8: With `dl_mode` = 1 the codes and `clr_n` are ignored. With `dl_en` = 1, `q` follows `dl_d` two edges later. With `dl_en` = 0, `q` holds.
- R9: When `thr_code` and `trg_code` carry the same value x (mode 0), the block behaves as an AND-NOT gate with hysteresis. x above the control code gives 0. x below half of it gives `clr_n`. x between the two holds the previous value.
- R10: A synchronous active-high `rst` clears `q` to 0 and empties the decision stage, so `q` is still 0 on the first edge after `rst` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_code | input | 8 | Sampled threshold level code |
| trg_code | input | 8 | Sampled trigger level code |
| ctl_code | input | 8 | External control level code |
| ctl_ovr | input | 1 | 1 selects `ctl_code`, 0 selects the default 170 |
| clr_n | input | 1 | Active-low clear, dominant over set |
| dl_mode | input | 1 | 1 selects transparent D-latch mapping |
| dl_en | input | 1 | D-latch enable (active high) |
| dl_d | input | 1 | D-latch data |
| q | output | 1 | Latch state as a logic level |
| dis_pull | output | 1 | Discharge pull-low enable (inverse of q) |
| dis_pad | output | 1 | Discharge pad value: 0 or z |

## Verification
The two functions that can fall in the same cycle are the set path and the clear path. The set path is a trigger code below half of the control level. The clear path is a threshold code above the control level or a low `clr_n`. Directed cases apply both requests at once, and random stimulus does the same through independent code draws that often land on both sides of both comparison points. The outcome is judged two edges later against a bench model in which clear always wins. The clear-beats-set property is also watched by a bound assertion throughout the run.

// File: rtl/tl_pkg.sv
package tl_pkg;

    localparam int CODE_W      = 8;
    localparam int FULL_SCALE  = (1 << CODE_W) - 1;
    localparam int CTL_DEFAULT = (2 * FULL_SCALE) / 3;

    typedef logic [CODE_W-1:0] code_t;

    // Decisions captured by the first pipeline stage.
    typedef struct packed {
        logic set_req;   // trigger below half control
        logic thr_req;   // threshold above control
        logic clr_n;     // active-low dominant clear
    } req_t;

    localparam req_t REQ_IDLE = '{set_req: 1'b0, thr_req: 1'b0, clr_n: 1'b1};

    function automatic code_t half_of(input code_t c);
        return c >> 1;
    endfunction

endpackage

// File: rtl/tl_decide.sv
module tl_decide
    import tl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  code_t thr_code,
    input  code_t trg_code,
    input  code_t ctl_code,
    input  logic  ctl_ovr,
    input  logic  clr_n,
    input  logic  dl_mode,
    input  logic  dl_en,
    input  logic  dl_d,
    output req_t  req_q
);

    code_t ctl_eff;
    req_t  req_d;

    always_comb begin
        ctl_eff = ctl_ovr ? ctl_code : code_t'(CTL_DEFAULT);
        if (dl_mode) begin
            // Trigger pin driven by inverted enable: request active when enabled.
            req_d.set_req = dl_en;
            req_d.thr_req = 1'b0;
            req_d.clr_n   = dl_d | ~dl_en;
        end else begin
            req_d.set_req = (trg_code < half_of(ctl_eff));
            req_d.thr_req = (thr_code > ctl_eff);
            req_d.clr_n   = clr_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) req_q <= REQ_IDLE;
        else     req_q <= req_d;
    end

endmodule

// File: rtl/tl_state.sv
module tl_state
    import tl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  req_t req,
    output logic state
);

    logic do_clear;
    logic do_set;

    always_comb begin
        do_clear = req.thr_req | ~req.clr_n;
        do_set   = req.set_req & ~do_clear;
    end

    always_ff @(posedge clk) begin
        if (rst)           state <= 1'b0;
        else if (do_clear) state <= 1'b0;
        else if (do_set)   state <= 1'b1;
    end

endmodule

// File: rtl/tl_drive.sv
module tl_drive (
    input  logic state,
    output logic q,
    output logic dis_pull,
    output logic dis_pad
);

    assign q        = state;
    assign dis_pull = ~state;
    assign dis_pad  = dis_pull ? 1'b0 : 1'bz;

endmodule

// File: rtl/timer_latch_core.sv
module timer_latch_core
    import tl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] thr_code,
    input  logic [CODE_W-1:0] trg_code,
    input  logic [CODE_W-1:0] ctl_code,
    input  logic              ctl_ovr,
    input  logic              clr_n,
    input  logic              dl_mode,
    input  logic              dl_en,
    input  logic              dl_d,
    output logic              q,
    output logic              dis_pull,
    output logic              dis_pad
);

    req_t req_q;
    logic state;

    tl_decide u_decide (
        .clk      (clk),
        .rst      (rst),
        .thr_code (thr_code),
        .trg_code (trg_code),
        .ctl_code (ctl_code),
        .ctl_ovr  (ctl_ovr),
        .clr_n    (clr_n),
        .dl_mode  (dl_mode),
        .dl_en    (dl_en),
        .dl_d     (dl_d),
        .req_q    (req_q)
    );

    tl_state u_state (
        .clk   (clk),
        .rst   (rst),
        .req   (req_q),
        .state (state)
    );

    tl_drive u_drive (
        .state    (state),
        .q        (q),
        .dis_pull (dis_pull),
        .dis_pad  (dis_pad)
    );

endmodule

// File: rtl/timer_latch_core_chk.sv
module timer_latch_core_chk
    import tl_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [7:0]  thr_code,
    input logic [7:0]  trg_code,
    input logic [7:0]  ctl_code,
    input logic        ctl_ovr,
    input logic        clr_n,
    input logic        dl_mode,
    input logic        dl_en,
    input logic        dl_d,
    input logic        q,
    input logic        dis_pull
);

    logic [7:0] ctl_ref;
    assign ctl_ref = ctl_ovr ? ctl_code : 8'd170;

    // R7: discharge enable mirrors the inverted output
    a_r7_dis_mirror: assert property (@(posedge clk) disable iff (rst)
        dis_pull == ~q);

    // R5: a low clear empties the state two edges later, regardless of trigger
    a_r5_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (!dl_mode && !clr_n) |=> ##1 !q);

    // R1: threshold above control clears
    a_r1_thr_clears: assert property (@(posedge clk) disable iff (rst)
        (!dl_mode && thr_code > ctl_ref) |=> ##1 !q);

    // R10: reset leaves the state cleared
    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> !q);

    // R8: enabled D latch with data 1 sets
    a_r8_follow_one: assert property (@(posedge clk) disable iff (rst)
        (dl_mode && dl_en && dl_d) |=> ##1 q);

    // R8: disabled D latch holds
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (dl_mode && !dl_en) |=> ##1 $stable(q));

endmodule

bind timer_latch_core timer_latch_core_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .thr_code (thr_code),
    .trg_code (trg_code),
    .ctl_code (ctl_code),
    .ctl_ovr  (ctl_ovr),
    .clr_n    (clr_n),
    .dl_mode  (dl_mode),
    .dl_en    (dl_en),
    .dl_d     (dl_d),
    .q        (q),
    .dis_pull (dis_pull)
);

// File: tb/sim_timer_latch_core.sv
`timescale 1ns/1ps
module sim_timer_latch_core;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] thr_code = 8'd0;
    logic [7:0] trg_code = 8'd255;
    logic [7:0] ctl_code = 8'd0;
    logic       ctl_ovr = 1'b0;
    logic       clr_n = 1'b1;
    logic       dl_mode = 1'b0;
    logic       dl_en = 1'b0;
    logic       dl_d = 1'b0;
    logic       q, dis_pull, dis_pad;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    timer_latch_core u0 (
        .clk(clk), .rst(rst), .thr_code(thr_code), .trg_code(trg_code),
        .ctl_code(ctl_code), .ctl_ovr(ctl_ovr), .clr_n(clr_n),
        .dl_mode(dl_mode), .dl_en(dl_en), .dl_d(dl_d),
        .q(q), .dis_pull(dis_pull), .dis_pad(dis_pad)
    );

    // Expected-value model built from the requirements.
    logic m_set, m_clr, m_q;

    function automatic logic f_set(input logic [7:0] tg, input logic [7:0] cc,
                                   input logic ov, input logic cn,
                                   input logic md, input logic en, input logic d);
        logic [7:0] c;
        c = ov ? cc : 8'd170;                        // R3
        if (md) return en & (d | ~en);               // R8
        return (tg < (c >> 1)) && cn;                // R2, R4
    endfunction

    function automatic logic f_clr(input logic [7:0] th, input logic [7:0] cc,
                                   input logic ov, input logic cn,
                                   input logic md, input logic en, input logic d);
        logic [7:0] c;
        c = ov ? cc : 8'd170;
        if (md) return ~(d | ~en);                   // R8
        return (th > c) || !cn;                      // R1, R5
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_set <= 1'b0; m_clr <= 1'b0; m_q <= 1'b0;
        end else begin
            m_set <= f_set(trg_code, ctl_code, ctl_ovr, clr_n, dl_mode, dl_en, dl_d);
            m_clr <= f_clr(thr_code, ctl_code, ctl_ovr, clr_n, dl_mode, dl_en, dl_d);
            if (m_clr)      m_q <= 1'b0;
            else if (m_set) m_q <= 1'b1;
        end
    end

    task automatic check(input string tag);
        total++;
        if (q !== m_q) begin
            bad++;
            $display("FAIL %s q actual=%b expected=%b", tag, q, m_q);
        end
        total++;
        if (dis_pull !== ~m_q || dis_pad !== (m_q ? 1'bz : 1'b0)) begin
            bad++;
            $display("FAIL R7 discharge actual=%b/%b expected=%b/%b",
                     dis_pull, dis_pad, ~m_q, (m_q ? 1'bz : 1'b0));
        end
    endtask

    task automatic step(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(tag);
        end
    endtask

    task automatic drive(input logic [7:0] th, input logic [7:0] tg,
                         input logic cn, input string tag);
        thr_code = th; trg_code = tg; clr_n = cn;
        step(tag, 2);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd5150));
        step("R10", 3);
        rst = 1'b0;
        step("R10", 1);                      // R10: q still 0 after release

        // Default control 170 / half 85 (R3)
        drive(8'd0, 8'd84, 1'b1, "R2");      // set
        drive(8'd170, 8'd200, 1'b1, "R1");   // equal: no clear
        drive(8'd171, 8'd200, 1'b1, "R1");   // clear
        drive(8'd0, 8'd85, 1'b1, "R2");      // equal half: no set
        drive(8'd0, 8'd10, 1'b1, "R4");
        drive(8'd0, 8'd200, 1'b1, "R6");     // hold 1
        // Both requests at once
        drive(8'd250, 8'd5, 1'b1, "R5");
        drive(8'd0, 8'd5, 1'b1, "R4");
        drive(8'd0, 8'd5, 1'b0, "R5");       // clr_n low beats trigger

        // Override control 100 / half 50
        ctl_ovr = 1'b1; ctl_code = 8'd100;
        drive(8'd0, 8'd50, 1'b1, "R3");
        drive(8'd0, 8'd49, 1'b1, "R3");
        drive(8'd100, 8'd200, 1'b1, "R3");
        drive(8'd101, 8'd200, 1'b1, "R3");
        ctl_ovr = 1'b0;

        // Tied input with hysteresis
        drive(8'd50, 8'd50, 1'b1, "R9");
        drive(8'd120, 8'd120, 1'b1, "R9");
        drive(8'd200, 8'd200, 1'b1, "R9");
        drive(8'd120, 8'd120, 1'b1, "R9");
        drive(8'd50, 8'd50, 1'b0, "R9");

        // D-latch mode, codes set to values that would clear
        dl_mode = 1'b1; thr_code = 8'd255; trg_code = 8'd255; clr_n = 1'b0;
        dl_en = 1'b1; dl_d = 1'b1; step("R8", 2);
        dl_en = 1'b0; dl_d = 1'b0; step("R8", 3);
        dl_en = 1'b1; step("R8", 2);
        dl_en = 1'b0; dl_d = 1'b1; step("R8", 3);
        dl_mode = 1'b0; clr_n = 1'b1; thr_code = 8'd0; trg_code = 8'd0;
        step("R4", 2);

        // Reset in mid-operation
        rst = 1'b1; step("R10", 1);
        rst = 1'b0; step("R10", 1);

        // Random mix
        for (int k = 0; k < 3000; k++) begin
            thr_code = 8'($urandom_range(255));
            trg_code = ($urandom_range(1) == 1) ? thr_code : 8'($urandom_range(255));
            ctl_ovr  = 1'($urandom_range(1));
            ctl_code = 8'($urandom_range(255));
            clr_n    = ($urandom_range(7) != 0);
            dl_mode  = ($urandom_range(5) == 0);
            dl_en    = 1'($urandom_range(1));
            dl_d     = 1'($urandom_range(1));
            rst      = ($urandom_range(199) == 0);
            @(negedge clk);
            if (m_clr)      check("R5");
            else if (m_set) check("R4");
            else            check("R6");
        end
        rst = 1'b0;
        step("R6", 2);
        finish_run();
    end

endmodule